// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches the clock and data lines of a two-wire serial bus and flags three timing faults. The first is the clock line held low for too long. The second is both lines resting high, which marks an idle bus. The third is the clock line high while the data line is stuck low. Both line inputs are synchronized inside the block before use.

A single 16-bit limit sets every threshold. The low-clock check compares its run length against the full limit. The two high-level checks compare theirs against the limit shifted right by nine bits. A run length is counted in ticks. A control bit chooses the tick rate: every clock cycle, or one tick every 64 cycles.

Firmware uses a small byte-wide register port. Through it, firmware loads the limit, sets the tick rate and the interrupt enable, reads the three flags and clears the clearable ones. The interrupt output follows the clock-high/data-low flag when the enable is set.

Top module: `bus_timeout_mon`

Register map (byte port, read data appears one cycle after the address):

| Addr | Read | Write |
|------|------|-------|
| 0 | committed limit bits 15:8 | stage limit bits 15:8 |
| 1 | committed limit bits 7:0 | commit {staged, data} as new limit |
| 2 | bit0 irq enable, bit1 fast tick | same fields |
| 3 | bit0 low flag, bit1 idle flag, bit2 stuck flag | 1 clears bit0 / bit2, bit1 ignored |

## Requirements
- R1: With control bit1 = 1, the timeout counters advance on every clock cycle. With bit1 = 0, they advance once every 64 cycles.
- R2: With a nonzero limit L, status bit0 (low flag) sets once the synchronized clock line has been low for more than L ticks. The flag stays set after the line returns high.
- R3: With the limit equal to zero, status bit0 never sets, however long the clock line stays low.
- R4: Writing 1 to status bit0 or bit2 clears that flag. Writing 0 leaves both flags unchanged.
- R5: Status bit1 (idle flag) sets once both lines have been high for more than (limit >> 9) ticks. It clears by itself when either line goes low. Writes to status bit1 have no effect.
- R6: Status bit2 (stuck flag) sets once the clock line has been high with the data line low for more than (limit >> 9) ticks.
- R7: irq_o is a registered copy of status bit2 AND control bit0. With control bit0 = 0, irq_o stays 0 even when the stuck flag is set.
- R8: A write to address 0 only stages the upper byte. The limit, and its readback at addresses 0 and 1, changes only when address 1 is written.
- R9: When (limit >> 9) is zero, the idle flag and the stuck flag never set.
- R10: Each counter saturates rather than wrapping. A flag sets at most once per continuous episode of its condition, so after a clear it stays clear until the condition ends and starts again.
- R11: If a flag's set event and a write-one clear of that flag fall in the same cycle, the flag ends up set.
- R12: After reset, every register reads 0 and irq_o is 0. Read data for an address appears one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data for reg_addr_i |
| irq_o | output | 1 | Stuck-condition interrupt |

## Verification
At the fast tick rate, a line change made between edges E0 and E0+1 reaches the synchronized state at edge E0+2. A flag with threshold T then sets at edge E0+3+T, and irq_o follows one edge later. A read samples the flags one edge after its address is presented. The bench therefore waits T+2 edges after the change and reads twice in a row: the first read must show the flag clear and the second must show it set. This pins the set edge exactly, and the same edge is used to make a clear collide with a set. At the divided rate the tick phase is free-running, so those checks use windows that are safely below and above the 64-cycle tick bounds.

// File: rtl/tm_pkg.sv
package tm_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_LIM_HI = 2'd0;
  localparam logic [ADDR_W-1:0] A_LIM_LO = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT   = 2'd3;

  localparam int B_IRQ_EN   = 0;
  localparam int B_FAST     = 1;
  localparam int B_LOW      = 0;
  localparam int B_IDLE     = 1;
  localparam int B_STUCK    = 2;

  localparam int NUM_COND   = 3;
  localparam int IDX_LOW    = 0;
  localparam int IDX_IDLE   = 1;
  localparam int IDX_STUCK  = 2;
endpackage

// File: rtl/tm_sync.sv
module tm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tm_tick.sv
module tm_tick #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic fast_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst)              pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                  pre_q <= pre_q + 1'b1;
  end

  assign tick_o = fast_i || (pre_q == LAST);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (!fast_i && tick_o) |=> (fast_i || !tick_o)); // R1
endmodule

// File: rtl/tm_cond_timer.sv
module tm_cond_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cond_i,
  input  logic         tick_i,
  input  logic [W-1:0] thr_i,
  output logic         fire_o
);
  logic [W-1:0] cnt_q;
  logic         done_q;

  assign fire_o = cond_i && tick_i && !done_q && (thr_i != '0) && (cnt_q == thr_i);

  always_ff @(posedge clk) begin
    if (rst || !cond_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (tick_i && (cnt_q != {W{1'b1}})) cnt_q <= cnt_q + 1'b1;
      if (fire_o) done_q <= 1'b1;
    end
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    cond_i |=> (cnt_q >= $past(cnt_q))); // R10
  AST_ONE_FIRE: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> !fire_o); // R10
endmodule

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon
  import tm_pkg::*;
#(
  parameter int PRESCALE    = 64,
  parameter int HI_SHIFT    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int LIMIT_W = 2 * DATA_W;

  logic scl_s, sda_s, tick;

  tm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
    .clk(clk), .rst(rst), .d_i(scl_i), .q_o(scl_s));
  tm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
    .clk(clk), .rst(rst), .d_i(sda_i), .q_o(sda_s));

  // configuration registers
  logic [LIMIT_W-1:0] limit_q;
  logic [DATA_W-1:0]  stage_hi_q;
  logic               irq_en_q, fast_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q    <= '0;
      stage_hi_q <= '0;
      irq_en_q   <= 1'b0;
      fast_q     <= 1'b0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        A_LIM_HI: stage_hi_q <= reg_wdata_i;
        A_LIM_LO: limit_q    <= {stage_hi_q, reg_wdata_i};
        A_CTRL: begin
          irq_en_q <= reg_wdata_i[B_IRQ_EN];
          fast_q   <= reg_wdata_i[B_FAST];
        end
        default: ;
      endcase
    end
  end

  tm_tick #(.DIV(PRESCALE)) u_tick (
    .clk(clk), .rst(rst), .fast_i(fast_q), .tick_o(tick));

  // condition timers
  logic [LIMIT_W-1:0]  hi_thr;
  logic [NUM_COND-1:0] cond_v, fire_v;

  assign hi_thr            = limit_q >> HI_SHIFT;
  assign cond_v[IDX_LOW]   = !scl_s;
  assign cond_v[IDX_IDLE]  = scl_s && sda_s;
  assign cond_v[IDX_STUCK] = scl_s && !sda_s;

  for (genvar g = 0; g < NUM_COND; g++) begin : g_tmr
    tm_cond_timer #(.W(LIMIT_W)) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .cond_i (cond_v[g]),
      .tick_i (tick),
      .thr_i  ((g == IDX_LOW) ? limit_q : hi_thr),
      .fire_o (fire_v[g])
    );
  end

  // flags
  logic low_flag_q, idle_flag_q, stuck_flag_q;
  logic clr_low, clr_stuck;

  assign clr_low   = reg_wr_i && (reg_addr_i == A_STAT) && reg_wdata_i[B_LOW];
  assign clr_stuck = reg_wr_i && (reg_addr_i == A_STAT) && reg_wdata_i[B_STUCK];

  always_ff @(posedge clk) begin
    if (rst) begin
      low_flag_q   <= 1'b0;
      idle_flag_q  <= 1'b0;
      stuck_flag_q <= 1'b0;
    end else begin
      low_flag_q   <= (low_flag_q && !clr_low) || fire_v[IDX_LOW];
      stuck_flag_q <= (stuck_flag_q && !clr_stuck) || fire_v[IDX_STUCK];
      idle_flag_q  <= cond_v[IDX_IDLE] && (idle_flag_q || fire_v[IDX_IDLE]);
    end
  end

  // registered outputs
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      A_LIM_HI: rd_mux = limit_q[LIMIT_W-1:DATA_W];
      A_LIM_LO: rd_mux = limit_q[DATA_W-1:0];
      A_CTRL: begin
        rd_mux[B_IRQ_EN] = irq_en_q;
        rd_mux[B_FAST]   = fast_q;
      end
      default: begin
        rd_mux[B_LOW]   = low_flag_q;
        rd_mux[B_IDLE]  = idle_flag_q;
        rd_mux[B_STUCK] = stuck_flag_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
      irq_o       <= 1'b0;
    end else begin
      reg_rdata_o <= rd_mux;
      irq_o       <= stuck_flag_q && irq_en_q;
    end
  end

  AST_LOW_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (limit_q == '0) |=> !$rose(low_flag_q)); // R3
  AST_HI_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (hi_thr == '0) |=> !$rose(stuck_flag_q)); // R9
  AST_IDLE_AUTOCLR: assert property (@(posedge clk) disable iff (rst)
    !cond_v[IDX_IDLE] |=> !idle_flag_q); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !irq_en_q |=> !irq_o); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    fire_v[IDX_LOW] |=> low_flag_q); // R11
  AST_LOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    (low_flag_q && !clr_low) |=> low_flag_q); // R4
endmodule

// File: tb/bus_timeout_mon_tb.sv
module bus_timeout_mon_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1, sda = 1'b1;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  bus_timeout_mon u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    addr = a;
    @(posedge clk); #1;
    d = rdata;
  endtask

  task automatic idle_cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_limit(logic [15:0] v);
    wr_reg(2'd0, v[15:8]);
    wr_reg(2'd1, v[7:0]);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), d);
      chk("R12 reset register", d, 8'h00);
    end
    chk("R12 reset irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_staging();
    logic [7:0] d;
    wr_reg(2'd0, 8'h12);
    rd_reg(2'd0, d);
    chk("R8 upper byte staged only", d, 8'h00);
    wr_reg(2'd1, 8'h34);
    rd_reg(2'd0, d);
    chk("R8 committed upper", d, 8'h12);
    rd_reg(2'd1, d);
    chk("R8 committed lower", d, 8'h34);
  endtask

  task automatic t_zero_limit();
    logic [7:0] d;
    set_limit(16'h0000);
    wr_reg(2'd2, 8'h02);
    scl = 1'b0;
    idle_cycles(300);
    rd_reg(2'd3, d);
    chk("R3 zero limit no low flag", d & 8'h01, 8'h00);
    scl = 1'b1;
    idle_cycles(5);
  endtask

  task automatic t_low_exact();
    logic [7:0] d;
    set_limit(16'd20);
    idle_cycles(100);
    rd_reg(2'd3, d);
    chk("R9 zero high threshold no idle flag", d & 8'h02, 8'h00);
    scl = 1'b0;
    idle_cycles(22);
    rd_reg(2'd3, d);
    chk("R2 low flag clear one edge early", d & 8'h01, 8'h00);
    rd_reg(2'd3, d);
    chk("R2 low flag set at limit", d & 8'h01, 8'h01);
    scl = 1'b1;
    idle_cycles(10);
    rd_reg(2'd3, d);
    chk("R2 low flag sticky", d & 8'h01, 8'h01);
    wr_reg(2'd3, 8'h00);
    rd_reg(2'd3, d);
    chk("R4 write zero no effect", d & 8'h01, 8'h01);
    wr_reg(2'd3, 8'h01);
    rd_reg(2'd3, d);
    chk("R4 write one clears low", d & 8'h01, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    scl = 1'b0;
    idle_cycles(22);
    addr = 2'd3; wdata = 8'h01; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
    rd_reg(2'd3, d);
    chk("R11 set beats clear", d & 8'h01, 8'h01);
    wr_reg(2'd3, 8'h01);
    idle_cycles(40);
    rd_reg(2'd3, d);
    chk("R10 no re-set in same episode", d & 8'h01, 8'h00);
    scl = 1'b1;
    idle_cycles(5);
  endtask

  task automatic t_stage_effect();
    logic [7:0] d;
    wr_reg(2'd0, 8'h01);
    scl = 1'b0;
    idle_cycles(30);
    scl = 1'b1;
    idle_cycles(5);
    rd_reg(2'd3, d);
    chk("R8 staged byte not yet in effect", d & 8'h01, 8'h01);
    wr_reg(2'd3, 8'h01);
    wr_reg(2'd1, 8'd20);
    scl = 1'b0;
    idle_cycles(60);
    scl = 1'b1;
    idle_cycles(5);
    rd_reg(2'd3, d);
    chk("R8 committed limit 0x0114 in effect", d & 8'h01, 8'h00);
  endtask

  task automatic t_idle_stuck();
    logic [7:0] d;
    set_limit(16'h0A00);
    wr_reg(2'd2, 8'h03);
    scl = 1'b0;
    idle_cycles(10);
    scl = 1'b1;
    idle_cycles(7);
    rd_reg(2'd3, d);
    chk("R5 idle flag clear one edge early", d & 8'h02, 8'h00);
    rd_reg(2'd3, d);
    chk("R5 idle flag set", d & 8'h02, 8'h02);
    wr_reg(2'd3, 8'h02);
    rd_reg(2'd3, d);
    chk("R5 idle flag ignores writes", d & 8'h02, 8'h02);
    sda = 1'b0;
    idle_cycles(7);
    rd_reg(2'd3, d);
    chk("R5 idle auto clear, R6 stuck not yet", d & 8'h06, 8'h00);
    rd_reg(2'd3, d);
    chk("R6 stuck flag set", d & 8'h06, 8'h04);
    chk("R7 irq follows stuck flag", {7'd0, irq}, 8'h01);
    wr_reg(2'd2, 8'h02);
    idle_cycles(2);
    chk("R7 irq masked when disabled", {7'd0, irq}, 8'h00);
    rd_reg(2'd3, d);
    chk("R7 stuck flag kept while masked", d & 8'h04, 8'h04);
    wr_reg(2'd3, 8'h04);
    idle_cycles(30);
    rd_reg(2'd3, d);
    chk("R4 R10 stuck cleared and not re-set", d & 8'h04, 8'h00);
    sda = 1'b1;
    idle_cycles(5);
  endtask

  task automatic t_divided();
    logic [7:0] d;
    set_limit(16'd3);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd3, 8'h05);
    scl = 1'b0;
    idle_cycles(20);
    rd_reg(2'd3, d);
    chk("R1 divided tick slows low flag", d & 8'h01, 8'h00);
    idle_cycles(330);
    rd_reg(2'd3, d);
    chk("R1 divided tick low flag set", d & 8'h01, 8'h01);
    scl = 1'b1;
    idle_cycles(5);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_staging();
    t_zero_limit();
    t_low_exact();
    t_set_wins();
    t_stage_effect();
    t_idle_stuck();
    t_divided();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule